// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block looks after the retained settings of a small bank of output channels. It holds a behavioural model of the retained storage words and, as soon as power-on reset is released, tells the channels' live registers to reload from storage. It does this with no serial clock edges at all. When the chip-select line falls, it asks for the same reload of every channel.

A commit is armed by a rising edge on the program pin while chip select is high. At that moment the sequencer captures the addressed channel and that channel's live value. The erase/write cycle is then paced entirely by the external serial clock. The busy state begins on the first falling serial clock edge, and the storage word is written only after a parameterised number of further falling edges. If the serial clock stops, the cycle stalls.

All inputs are sampled on the system clock, and serial clock edges are found by comparing each sample with the previous one.

Top module: `nvs_sequencer`

## Requirements
- R1: In the first system clock cycle after `rstN` is released, `reloadEn` is all ones for exactly one cycle, and `sclkIn` needs no edges for this to happen.
- R2: A commit request is a rising edge of `progIn` sampled while `csIn` is high. A rising edge while `csIn` is low is ignored: no busy state and no `storeWe` pulse follow.
- R3: `readyOut` stays 1 after a request until the first falling `sclkIn` edge is sampled. In the cycle after that edge is sampled, `readyOut` is 0.
- R4: While busy, `readyOut` stays 0 for as long as no falling `sclkIn` edge is sampled, however long the serial clock is held.
- R5: After `WRITE_TICKS` further falling `sclkIn` edges, the storage word of the captured channel takes the captured value, and `readyOut` returns to 1. The stored word for channel k appears at `storedVals[k*WIDTH +: WIDTH]`. `storeWe` pulses bit k for one cycle, in the same cycle that `readyOut` returns to 1.
- R6: A commit whose value already equals the stored word still runs the full cycle and still pulses `storeWe`.
- R7: Program edges that arrive while a cycle is armed or busy are ignored. The channel and value written are the ones captured at the request, whatever `chanSel` or `liveVals` do afterwards.
- R8: A falling edge of `csIn` sampled at clock edge e makes `reloadEn` all ones for one cycle after edge e+1. If an erase/write cycle is armed or busy at that time, the reload waits until the cycle has completed, and it pulses only after the `storeWe` pulse.
- R9: Storage words keep their values across `rstN`. The reload after reset presents the previously committed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| progIn | input | 1 | Program request pin |
| sclkIn | input | 1 | Serial clock, sampled as data; its falling edges pace the write |
| csIn | input | 1 | Chip select, active high |
| chanSel | input | SEL_W | Currently addressed channel |
| liveVals | input | NUM_CH*WIDTH | Live register values, channel k at bits k*WIDTH |
| storeWe | output | NUM_CH | One-cycle write strobe per storage word |
| storeData | output | WIDTH | Value captured for the pending write |
| reloadEn | output | NUM_CH | Reload strobe for the live registers |
| storedVals | output | NUM_CH*WIDTH | Contents of the storage words |
| readyOut | output | 1 | 1 = ready, 0 = erase/write in progress |

## Verification
Every result is registered one system clock after the sampled input that causes it. Busy is therefore due in the cycle after the clock edge that sees `sclkIn` go low. The write strobe and the return to ready are due in the cycle after the edge that sees the last counted fall. A reload is due one cycle later still, because it goes through a pending flag. The bench drives its inputs one time unit after a rising edge. It updates a behavioural model at that rising edge and compares every output at the following falling edge, so each expectation is checked in exactly the cycle it is due. Directed checks then count strobe pulses around stalls, ignored requests and deferred reloads.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_BUSY  = 2'd2
  } seqState_e;

  typedef struct packed {
    logic capture;
    logic commit;
  } nvStrobe_t;
endpackage

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int WRITE_TICKS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      progIn,
  input  logic      sclkIn,
  input  logic      csIn,
  output nvStrobe_t strobe,
  output logic      reloadAll,
  output logic      readyOut
);
  localparam int CW = $clog2(WRITE_TICKS + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(WRITE_TICKS - 1);

  seqState_e state;
  logic [CW-1:0] tickCnt;
  logic progQ, sclkQ, csQ, reloadPend;
  logic progRise, sclkFall, csFall;

  assign progRise = progIn & ~progQ;
  assign sclkFall = sclkQ & ~sclkIn;
  assign csFall   = csQ & ~csIn;
  assign readyOut = (state != SEQ_BUSY);

  always_comb begin
    strobe.capture = (state == SEQ_IDLE) && progRise && csIn;
    strobe.commit  = (state == SEQ_BUSY) && sclkFall && (tickCnt == LAST_TICK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      tickCnt    <= '0;
      progQ      <= 1'b1;
      sclkQ      <= 1'b0;
      csQ        <= 1'b0;
      reloadPend <= 1'b1;
      reloadAll  <= 1'b0;
    end else begin
      progQ     <= progIn;
      sclkQ     <= sclkIn;
      csQ       <= csIn;
      reloadAll <= 1'b0;
      case (state)
        SEQ_IDLE:  if (strobe.capture) state <= SEQ_ARMED;
        SEQ_ARMED: if (sclkFall) begin
          state   <= SEQ_BUSY;
          tickCnt <= '0;
        end
        SEQ_BUSY:  if (sclkFall) begin
          if (strobe.commit) state <= SEQ_IDLE;
          else tickCnt <= tickCnt + 1'b1;
        end
        default:   state <= SEQ_IDLE;
      endcase
      if (csFall) reloadPend <= 1'b1;
      else if (reloadPend && state == SEQ_IDLE) begin
        reloadPend <= 1'b0;
        reloadAll  <= 1'b1;
      end
    end
  end

  // R3: busy can only begin after a sampled falling serial clock edge
  p_busy_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyOut) |-> $past(sclkFall));

  // R4: without a serial clock fall, a busy cycle stays busy
  p_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && !sclkFall) |=> !readyOut);

  // R8: no reload is issued while the write cycle is running
  p_no_reload_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |-> !reloadAll);
endmodule

// File: rtl/nvs_data.sv
module nvs_data
  import nvs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WIDTH  = 8,
  parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  nvStrobe_t               strobe,
  input  logic [SEL_W-1:0]        chanSel,
  input  logic [NUM_CH*WIDTH-1:0] liveVals,
  input  logic                    reloadAll,
  output logic [NUM_CH-1:0]       storeWe,
  output logic [WIDTH-1:0]        storeData,
  output logic [NUM_CH-1:0]       reloadEn,
  output logic [NUM_CH*WIDTH-1:0] storedVals
);
  logic [SEL_W-1:0] chanReg;
  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] storeMem [NUM_CH];

  assign storeData = dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanReg <= '0;
      dataReg <= '0;
      storeWe <= '0;
    end else begin
      if (strobe.capture) begin
        chanReg <= chanSel;
        dataReg <= liveVals[chanSel*WIDTH +: WIDTH];
      end
      storeWe <= strobe.commit ? (NUM_CH'(1) << chanReg) : '0;
    end
  end

  // retained words: deliberately untouched by reset
  for (genvar k = 0; k < NUM_CH; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (strobe.commit && chanReg == SEL_W'(k)) storeMem[k] <= dataReg;
    end
    assign storedVals[k*WIDTH +: WIDTH] = storeMem[k];
    assign reloadEn[k] = reloadAll;
  end

  // R5: at most one storage word is written, as a single-cycle strobe
  p_we_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(storeWe));
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|storeWe) |=> (storeWe == '0));

  // R9: storage changes only on a commit
  p_store_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(storedVals));
endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
  import nvs_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int WIDTH       = 8,
  parameter int WRITE_TICKS = 16,
  parameter int SEL_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    progIn,
  input  logic                    sclkIn,
  input  logic                    csIn,
  input  logic [SEL_W-1:0]        chanSel,
  input  logic [NUM_CH*WIDTH-1:0] liveVals,
  output logic [NUM_CH-1:0]       storeWe,
  output logic [WIDTH-1:0]        storeData,
  output logic [NUM_CH-1:0]       reloadEn,
  output logic [NUM_CH*WIDTH-1:0] storedVals,
  output logic                    readyOut
);
  nvStrobe_t strobe;
  logic reloadAll;

  nvs_ctrl #(.WRITE_TICKS(WRITE_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .progIn(progIn), .sclkIn(sclkIn), .csIn(csIn),
    .strobe(strobe), .reloadAll(reloadAll), .readyOut(readyOut)
  );

  nvs_data #(.NUM_CH(NUM_CH), .WIDTH(WIDTH), .SEL_W(SEL_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanSel(chanSel),
    .liveVals(liveVals), .reloadAll(reloadAll), .storeWe(storeWe),
    .storeData(storeData), .reloadEn(reloadEn), .storedVals(storedVals)
  );

  // R5: the write strobe coincides with the return to ready
  p_ready_with_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|storeWe) |-> readyOut);
endmodule

// File: tb/tb_nvs_sequencer.sv
module tb_nvs_sequencer;
  localparam int T = 16;

  logic clk = 0, rstN = 0, prog = 0, sclk = 0, cs = 0;
  logic [1:0] chan = 0;
  logic [31:0] live = 0;
  logic [3:0] storeWe, reloadEn;
  logic [7:0] storeData;
  logic [31:0] storedVals;
  logic readyOut;

  int total = 0, bad = 0, weCnt = 0, rlCnt = 0;

  nvs_sequencer #(.NUM_CH(4), .WIDTH(8), .WRITE_TICKS(T)) dut (
    .clk(clk), .rstN(rstN), .progIn(prog), .sclkIn(sclk), .csIn(cs),
    .chanSel(chan), .liveVals(live), .storeWe(storeWe), .storeData(storeData),
    .reloadEn(reloadEn), .storedVals(storedVals), .readyOut(readyOut)
  );

  always #2 clk = ~clk;

  // behavioural reference
  int mState = 0, mCnt = 0, mCh = 0, mWe = -1;
  bit mPq = 1, mSq = 0, mCq = 0, mPend = 1, mReload = 0;
  logic [7:0] mVal = 0;
  logic [7:0] mStore [4];
  bit mKnown [4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mPq = 1; mSq = 0; mCq = 0;
      mPend = 1; mReload = 0; mWe = -1;
    end else begin
      int oldState;
      bit pr, sf, cf;
      pr = prog && !mPq; sf = mSq && !sclk; cf = mCq && !cs;
      oldState = mState; mWe = -1; mReload = 0;
      if (oldState == 0 && pr && cs) begin
        mCh = int'(chan); mVal = live[chan*8 +: 8]; mState = 1;
      end else if (oldState == 1 && sf) begin
        mState = 2; mCnt = 0;
      end else if (oldState == 2 && sf) begin
        if (mCnt == T - 1) begin
          mStore[mCh] = mVal; mKnown[mCh] = 1; mWe = mCh; mState = 0;
        end else mCnt++;
      end
      if (cf) mPend = 1;
      else if (mPend && oldState == 0) begin mPend = 0; mReload = 1; end
      mPq = prog; mSq = sclk; mCq = cs;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (|storeWe) weCnt++;
    if (reloadEn == 4'hF) rlCnt++;
    check(readyOut == (mState != 2), "R3/R4/R5 readyOut", int'(readyOut), int'(mState != 2));
    check(reloadEn == (mReload ? 4'hF : 4'h0), "R1/R8 reloadEn", int'(reloadEn),
          mReload ? 15 : 0);
    check(storeWe == ((mWe < 0) ? 4'h0 : 4'(1 << mWe)), "R5/R6 storeWe", int'(storeWe),
          (mWe < 0) ? 0 : (1 << mWe));
    for (int k = 0; k < 4; k++)
      if (mKnown[k])
        check(storedVals[k*8 +: 8] == mStore[k], "R5/R9 storedVals",
              int'(storedVals[k*8 +: 8]), int'(mStore[k]));
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseSclk(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1; cyc(2);
      sclk = 0; cyc(2);
    end
  endtask

  task automatic request(int ch, logic [7:0] v);
    chan = 2'(ch); live[ch*8 +: 8] = v;
    prog = 1; cyc(2);
    prog = 0; cyc(1);
  endtask

  task automatic commit(int ch, logic [7:0] v);
    request(ch, v);
    check(readyOut == 1, "R3 ready before first fall", int'(readyOut), 1);
    pulseSclk(1);
    check(readyOut == 0, "R3 busy after first fall", int'(readyOut), 0);
    pulseSclk(T);
    cyc(1);
    check(storedVals[ch*8 +: 8] == v, "R5 stored word", int'(storedVals[ch*8 +: 8]), int'(v));
    check(readyOut == 1, "R5 ready after write", int'(readyOut), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, r0;
    cyc(3);
    check(readyOut == 1, "R1 ready in reset", int'(readyOut), 1);
    rstN = 1; cs = 1;
    cyc(3);
    check(rlCnt == 1, "R1 power-up reload without sclk", rlCnt, 1);

    for (int k = 0; k < 4; k++) commit(k, 8'(8'h11 * (k + 1)));

    w0 = weCnt;                                   // R6 equal value
    commit(1, 8'h22);
    check(weCnt == w0 + 1, "R6 equal value still written", weCnt, w0 + 1);

    request(2, 8'h5A);                            // R4 stall
    pulseSclk(4);
    sclk = 1; cyc(40);
    check(readyOut == 0, "R4 stalled stays busy", int'(readyOut), 0);
    sclk = 0; cyc(2);
    pulseSclk(T - 4);
    cyc(1);
    check(storedVals[23:16] == 8'h5A, "R4 stalled cycle completes", int'(storedVals[23:16]), 'h5A);

    request(3, 8'h77);                            // R7 ignored during busy
    pulseSclk(2);
    chan = 0; live[7:0] = 8'h99; live[31:24] = 8'hEE;
    prog = 1; cyc(2); prog = 0; cyc(1);
    pulseSclk(T - 1);
    cyc(2);
    check(storedVals[31:24] == 8'h77, "R7 captured value kept", int'(storedVals[31:24]), 'h77);
    check(storedVals[7:0] == 8'h11, "R7 second request ignored", int'(storedVals[7:0]), 'h11);
    check(readyOut == 1, "R7 no extra cycle", int'(readyOut), 1);

    w0 = weCnt;                                   // R2 cs low
    cs = 0; cyc(3);
    request(0, 8'hC3);
    pulseSclk(T + 2);
    check(weCnt == w0, "R2 request with cs low ignored", weCnt, w0);
    check(storedVals[7:0] == 8'h11, "R2 word unchanged", int'(storedVals[7:0]), 'h11);
    cs = 1; cyc(2);

    r0 = rlCnt;                                   // R8 idle cs fall
    cs = 0; cyc(3);
    check(rlCnt == r0 + 1, "R8 reload on cs fall", rlCnt, r0 + 1);
    cs = 1; cyc(2);

    r0 = rlCnt;                                   // R8 deferred
    request(0, 8'h3C);
    pulseSclk(2);
    cs = 0; cyc(2); cs = 1;
    cyc(10);
    check(rlCnt == r0, "R8 reload deferred while busy", rlCnt, r0);
    pulseSclk(T - 1);
    cyc(3);
    check(rlCnt == r0 + 1, "R8 reload after write", rlCnt, r0 + 1);

    r0 = rlCnt;                                   // R9 power cycle
    rstN = 0; cyc(3);
    rstN = 1; cyc(3);
    check(rlCnt == r0 + 1, "R9 reload after reset", rlCnt, r0 + 1);
    check(storedVals == 32'h775A_223C, "R9 words retained", int'(storedVals), 32'h775A223C);

    cyc(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule